// File: doc/BRIEF.md
# Card Hotswap Monitor

This block watches the card-detect contact of a removable memory-card socket and turns its noisy, asynchronous level into clean hotswap events. The contact is active low: a low level means a card sits in the socket. The raw level is brought into the clock domain by a flop chain. Every change of the synchronized level, in either direction, restarts a retriggerable one-shot timer. When the level has then held still for the full window, the block reads the level once and emits a single-cycle `insert_o` pulse if a card is present, or a `remove_o` pulse if the socket is empty.

Software or a mount manager uses the pulses as notifications and never sees contact bounce. The `mon_en_i` input switches monitoring on and off. While it is low, level changes are ignored and any window in progress is dropped. The synchronizer and the reference level both reset to the "socket empty" value. A card that is already seated when reset is released is therefore reported as an insertion.

Top module: `card_hotswap_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `insert_o` and `remove_o` are low. The internal level starts as "empty" (1), so a detect input held low from reset onward produces one `insert_o` pulse once the window has run.
- R2: The input value 0 means card present and 1 means socket empty. At expiry the block emits `insert_o` when the synchronized level is 0 and `remove_o` when it is 1.
- R3: If the input changes so that the new value is first sampled at rising edge c, and then stays constant, the event pulse is high in the cycle that follows rising edge c + STABLE_CYCLES + 2. The two synchronizer flops and the edge register account for the extra edges.
- R4: A change in either direction, seen while monitoring is enabled, reloads the timer with the full STABLE_CYCLES. An event needs the input to hold for STABLE_CYCLES + 1 consecutive sampling edges after the last change. A bounce that returns to the previous level still produces an event that reports that level.
- R5: While `mon_en_i` is low, no event is emitted, level changes do not start the timer, and a running timer is cancelled. Raising `mon_en_i` again does not resume a cancelled window.
- R6: Each pulse lasts exactly one cycle. `insert_o` and `remove_o` are never high together. Each timer expiry yields at most one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mon_en_i | input | 1 | Monitoring enable, synchronous to clk_i |
| detect_n_i | input | 1 | Raw socket contact, asynchronous, low = card present |
| insert_o | output | 1 | One-cycle pulse: card present after a stable window |
| remove_o | output | 1 | One-cycle pulse: socket empty after a stable window |

## Verification
A detect change first sampled at rising edge c yields a pulse after edge c + STABLE_CYCLES + 2. The level must hold through edge c + STABLE_CYCLES, and the enable must be sampled high at every edge from c + 2 up to the pulse edge. The bench records the detect and enable values it drives for each rising edge. After every edge it evaluates that rule for the current edge index and compares both outputs on the following falling edge, so the comparison always falls after the output register has settled. Directed segments place a second change one edge before and exactly on the first allowed edge, to probe both sides of the window boundary.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    // Level of the synchronized contact when no card is seated.
    localparam logic LVL_EMPTY = 1'b1;

    typedef struct packed {
        logic insert;
        logic remove;
    } hsw_evt_t;

endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    // Stage 0 takes the raw input, stage STAGES-1 is the safe output.
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hsw_edge.sv
module hsw_edge #(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic change_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= RESET_VAL;
        end else begin
            prev_q <= prev_d;
        end
    end

    // Rising and falling changes are treated alike.
    assign change_o = level_i ^ prev_q;
endmodule

// File: rtl/hsw_oneshot.sv
module hsw_oneshot #(
    parameter int STABLE_CYCLES = 37_500_000,
    parameter int CNT_W         = $clog2(STABLE_CYCLES + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic             trigger_i,
    output logic             expire_o,
    output logic             armed_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STABLE_CYCLES);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] count;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic fire;

    always_comb begin
        tmr_d = tmr_q;
        fire  = 1'b0;
        if (!enable_i) begin
            tmr_d.armed = 1'b0;
            tmr_d.count = '0;
        end else if (trigger_i) begin
            tmr_d.armed = 1'b1;
            tmr_d.count = LOAD_VAL;
        end else if (tmr_q.armed) begin
            if (tmr_q.count == LAST_VAL) begin
                fire        = 1'b1;
                tmr_d.armed = 1'b0;
                tmr_d.count = '0;
            end else begin
                tmr_d.count = tmr_q.count - LAST_VAL;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expire_o = fire;
    assign armed_o  = tmr_q.armed;
    assign count_o  = tmr_q.count;
endmodule

// File: rtl/card_hotswap_monitor.sv
module card_hotswap_monitor #(
    parameter int STABLE_CYCLES = 37_500_000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic mon_en_i,
    input  logic detect_n_i,
    output logic insert_o,
    output logic remove_o
);
    import hsw_pkg::*;

    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);

    logic             lvl_empty;
    logic             lvl_change;
    logic             tmr_expire;
    logic             tmr_armed;
    logic [CNT_W-1:0] tmr_count;

    hsw_evt_t evt_d, evt_q;

    hsw_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (LVL_EMPTY)
    ) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (detect_n_i),
        .sync_o  (lvl_empty)
    );

    hsw_edge #(
        .RESET_VAL (LVL_EMPTY)
    ) i_edge (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .level_i  (lvl_empty),
        .change_o (lvl_change)
    );

    hsw_oneshot #(
        .STABLE_CYCLES (STABLE_CYCLES),
        .CNT_W         (CNT_W)
    ) i_oneshot (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .enable_i  (mon_en_i),
        .trigger_i (lvl_change),
        .expire_o  (tmr_expire),
        .armed_o   (tmr_armed),
        .count_o   (tmr_count)
    );

    always_comb begin
        evt_d        = '0;
        evt_d.insert = tmr_expire && (lvl_empty != LVL_EMPTY);
        evt_d.remove = tmr_expire && (lvl_empty == LVL_EMPTY);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    assign insert_o = evt_q.insert;
    assign remove_o = evt_q.remove;
endmodule

// File: rtl/hsw_monitor_checker.sv
module hsw_monitor_checker #(
    parameter int STABLE_CYCLES = 37_500_000,
    parameter int CNT_W         = $clog2(STABLE_CYCLES + 1)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             mon_en_i,
    input logic             insert_o,
    input logic             remove_o,
    input logic             lvl_empty,
    input logic             lvl_change,
    input logic             tmr_armed,
    input logic [CNT_W-1:0] tmr_count
);
    p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(insert_o && remove_o));

    p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insert_o || remove_o) |=> !(insert_o || remove_o));

    p_quiet_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mon_en_i |=> !(insert_o || remove_o));

    p_cancel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mon_en_i |=> !tmr_armed);

    p_rearm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mon_en_i && lvl_change) |=> (tmr_armed && tmr_count == CNT_W'(STABLE_CYCLES)));

    p_change_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lvl_change |=> !(insert_o || remove_o));

    p_insert_dir_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        insert_o |-> !$past(lvl_empty));

    p_remove_dir_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        remove_o |-> $past(lvl_empty));

    p_count_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmr_armed |-> (tmr_count != '0 && tmr_count <= CNT_W'(STABLE_CYCLES)));
endmodule

bind card_hotswap_monitor hsw_monitor_checker #(
    .STABLE_CYCLES (STABLE_CYCLES),
    .CNT_W         (CNT_W)
) i_hsw_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mon_en_i   (mon_en_i),
    .insert_o   (insert_o),
    .remove_o   (remove_o),
    .lvl_empty  (lvl_empty),
    .lvl_change (lvl_change),
    .tmr_armed  (tmr_armed),
    .tmr_count  (tmr_count)
);

// File: tb/test_card_hotswap_monitor.sv
module test_card_hotswap_monitor;
    localparam int N    = 20;
    localparam int MAXE = 9000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic det_n = 1'b0;
    logic ins, rem;

    int n_tests = 0;
    int n_fail  = 0;
    int k       = 0;
    string tag  = "R1";

    logic din_h [0:MAXE-1];
    logic en_h  [0:MAXE-1];

    always #4 clk = ~clk;

    card_hotswap_monitor #(.STABLE_CYCLES(N), .SYNC_STAGES(2)) i_card_hotswap_monitor (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .mon_en_i   (en),
        .detect_n_i (det_n),
        .insert_o   (ins),
        .remove_o   (rem)
    );

    // Expected outputs after rising edge t, from the window rule.
    function automatic void expect_at(input int t, output logic e_ins, output logic e_rem);
        int c;
        logic prior;
        e_ins = 1'b0;
        e_rem = 1'b0;
        c = t - N - 2;
        if (c < 0) return;
        prior = (c == 0) ? 1'b1 : din_h[c-1];
        if (din_h[c] == prior) return;
        for (int j = c; j <= c + N; j++) if (din_h[j] != din_h[c]) return;
        for (int j = c + 2; j <= t; j++) if (!en_h[j]) return;
        if (din_h[c] == 1'b0) e_ins = 1'b1;
        else e_rem = 1'b1;
    endfunction

    task automatic check(input string rq, input logic act_i, input logic act_r,
                         input logic exp_i, input logic exp_r);
        n_tests++;
        if (act_i !== exp_i || act_r !== exp_r) begin
            n_fail++;
            $display("FAIL %s edge %0d: insert/remove=%0b%0b expected %0b%0b",
                     rq, k, act_i, act_r, exp_i, exp_r);
        end
    endtask

    // Drive at a falling edge, take one rising edge, check at the next falling edge.
    task automatic step(input logic d, input logic e);
        logic xi, xr;
        det_n = d;
        en    = e;
        @(posedge clk);
        din_h[k] = d;
        en_h[k]  = e;
        expect_at(k, xi, xr);
        @(negedge clk);
        check(tag, ins, rem, xi, xr);
        k++;
    endtask

    task automatic hold(input logic d, input int cycles);
        for (int i = 0; i < cycles; i++) step(d, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic lvl;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        check("R1", ins, rem, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R1: card already seated at reset release gives one insertion.
        tag = "R1";
        hold(1'b0, N + 10);
        // R2: removal after a clean stable window.
        tag = "R2";
        hold(1'b1, N + 8);
        // R3: insertion latency from a single clean change.
        tag = "R3";
        hold(1'b0, N + 8);
        // R4: bounce that ends on the previous level still reports it.
        tag = "R4";
        for (int b = 0; b < 4; b++) begin
            hold(1'b1, 3);
            hold(1'b0, 2);
        end
        hold(1'b0, N + 6);
        // R4: second change one edge before the window closes blocks the first.
        hold(1'b1, N);
        hold(1'b0, N + 6);
        // R4: second change exactly on the first allowed edge lets the first fire.
        hold(1'b1, N + 1);
        hold(1'b0, N + 6);
        // R5: enable drop in the middle of a window cancels it.
        tag = "R5";
        hold(1'b1, N / 2);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        hold(1'b1, N + 6);
        // R5: change while disabled is ignored after enable returns.
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
        hold(1'b0, N + 6);
        // R5: enable drop on the very edge of expiry.
        hold(1'b1, N + 1);
        step(1'b1, 1'b0);
        hold(1'b1, 6);
        // R6: random bounces and enable drops.
        tag = "R6";
        lvl = 1'b1;
        for (int s = 0; s < 120; s++) begin
            int toggles;
            toggles = $urandom_range(0, 4);
            for (int t = 0; t < toggles; t++) begin
                lvl = ~lvl;
                hold(lvl, $urandom_range(1, N));
            end
            if ($urandom_range(0, 9) == 0) begin
                int off;
                off = $urandom_range(1, 4);
                for (int i = 0; i < off; i++) step(lvl, 1'b0);
            end
            if ($urandom_range(0, 1) == 1) lvl = ~lvl;
            hold(lvl, $urandom_range(N - 2, N + 6));
        end
        hold(lvl, N + 4);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule